// File: doc/BRIEF.md
# Latching Relay Band Selector

This block drives the coils of six bistable relays. Each relay switches in one of six transmit low-pass filter bands. Every relay has its own set coil, and one reset coil is wired to all six relays. A latching relay holds its position with no current, so the block energises a coil only while a band change is under way. At all other times every drive line is low.

A band request is a select byte offered on a valid/ready handshake. When the block serves a request, it first pulses the shared reset coil so that every relay drops out. It then leaves all coils undriven for a short gap. Last, it pulses the set coil of the requested band. Pulse and gap lengths are counted in clock cycles. With the defaults, a 1 MHz clock gives a 5 ms pulse and a 1 ms gap.

The select byte uses a fixed scrambled bit-to-band mapping. A byte that does not name exactly one band produces only the reset pulse and raises an error flag. The block holds one request while a sequence runs. Back-pressure: `req_ready` is low whenever that one-entry holding slot is occupied. A producer must keep `req_valid` and `req_sel` steady until it sees `req_ready` high at a clock edge.

Top module: `relay_band_sel`

## Requirements
- R1: After reset every coil line is low, `busy` and `sel_err` are low and `req_ready` is high.
- R2: A request accepted while the block is idle makes `coil_reset` rise in the second cycle after the accepting edge. It stays high for exactly PULSE_CYC cycles.
- R3: After the reset pulse of a valid request, no coil is driven for exactly GAP_CYC cycles. Then one set line is high for exactly PULSE_CYC cycles.
- R4: The select bits map to set lines as follows: bit 6 to `coil_set[0]` (band 1), bit 4 to `coil_set[1]`, bit 2 to `coil_set[2]`, bit 1 to `coil_set[3]`, bit 3 to `coil_set[4]`, bit 5 to `coil_set[5]`.
- R5: Bits 0 and 7 of `req_sel` have no effect on which coils are pulsed or on `sel_err`.
- R6: No more than one coil line is high in any cycle.
- R7: `busy` is high from the first cycle of the reset pulse through the last cycle of the sequence and low otherwise. No coil is driven while `busy` is low.
- R8: A request accepted during a sequence is served after it. Its reset pulse starts after exactly one cycle with `busy` low.
- R9: If the six band bits are not exactly one-hot, only the reset pulse is issued. `sel_err` then goes high when that sequence starts and stays high until the next sequence starts; a valid request clears it at that point. No set line is driven while `sel_err` is high.
- R10: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after every acceptance and stays low while a request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Band request offered |
| req_ready | output | 1 | Holding slot free, request can be taken |
| req_sel | input | 8 | Band select byte (mapping in R4) |
| coil_set | output | 6 | Set coil drive, one per band |
| coil_reset | output | 1 | Shared reset coil drive |
| busy | output | 1 | Change sequence in progress |
| sel_err | output | 1 | Last served request was not one-hot |

## Verification
The bench builds the block with PULSE_CYC=6 and GAP_CYC=3 instead of the millisecond-scale defaults. With these values a full change sequence lasts about sixteen cycles. Hundreds of sequences, including back-to-back and held requests, therefore fit in a short run. The exact pulse and gap widths are still measured cycle by cycle, so an off-by-one in either count shows up at once.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int NUM_BANDS = 6;
  localparam int SEL_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RST,
    ST_GAP,
    ST_SET
  } seq_state_t;

  typedef struct packed {
    logic [NUM_BANDS-1:0] onehot;
    logic                 ok;
  } band_req_t;

  // Select-byte bit that names band index i (band 1 is index 0).
  function automatic int band_bit(input int idx);
    case (idx)
      0:       return 6;
      1:       return 4;
      2:       return 2;
      3:       return 1;
      4:       return 3;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/rbs_req_slot.sv
module rbs_req_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);

  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/rbs_decode.sv
module rbs_decode
  import rbs_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output band_req_t        req
);

  logic [NUM_BANDS-1:0] hit;

  for (genvar i = 0; i < NUM_BANDS; i++) begin : g_band
    assign hit[i] = sel[band_bit(i)];
  end

  always_comb begin
    req.ok     = ($countones(hit) == 1);
    req.onehot = req.ok ? hit : '0;
  end

endmodule

// File: rtl/rbs_timer.sv
module rbs_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/relay_band_sel.sv
module relay_band_sel
  import rbs_pkg::*;
#(
  parameter int PULSE_CYC = 5000,
  parameter int GAP_CYC   = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEL_W-1:0]     req_sel,
  output logic [NUM_BANDS-1:0] coil_set,
  output logic                 coil_reset,
  output logic                 busy,
  output logic                 sel_err
);

  localparam int MAX_CYC = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_t           state, state_nx;
  logic                 slot_full;
  logic [SEL_W-1:0]     slot_sel;
  logic                 take;
  band_req_t            dec;
  band_req_t            act;
  logic                 tmr_load;
  logic [CNT_W-1:0]     tmr_len;
  logic                 tmr_done;

  rbs_req_slot #(.DATA_W(SEL_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (req_sel),
    .take     (take),
    .full     (slot_full),
    .data     (slot_sel)
  );

  rbs_decode u_dec (
    .sel (slot_sel),
    .req (dec)
  );

  rbs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_done)
  );

  assign take = (state == ST_IDLE) && slot_full;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_len  = CNT_W'(PULSE_CYC);
    case (state)
      ST_IDLE: if (slot_full) begin
        state_nx = ST_RST;
        tmr_load = 1'b1;
      end
      ST_RST: if (tmr_done) begin
        if (act.ok) begin
          state_nx = ST_GAP;
          tmr_load = 1'b1;
          tmr_len  = CNT_W'(GAP_CYC);
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_GAP: if (tmr_done) begin
        state_nx = ST_SET;
        tmr_load = 1'b1;
      end
      default: if (tmr_done) begin
        state_nx = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      act     <= '0;
      sel_err <= 1'b0;
    end else begin
      state <= state_nx;
      if (take) begin
        act     <= dec;
        sel_err <= !dec.ok;
      end
    end
  end

  assign coil_reset = (state == ST_RST);
  assign coil_set   = (state == ST_SET) ? act.onehot : '0;
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int PULSE_CYC = 5000,
  parameter int GAP_CYC   = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [5:0] coil_set,
  input logic       coil_reset,
  input logic       busy,
  input logic       sel_err
);

  int rst_len, set_len, gap_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_len <= 0;
      set_len <= 0;
      gap_len <= 0;
    end else begin
      rst_len <= coil_reset ? rst_len + 1 : 0;
      set_len <= (|coil_set) ? set_len + 1 : 0;
      gap_len <= (busy && !coil_reset && !(|coil_set)) ? gap_len + 1 : 0;
    end
  end

  a_r2_reset_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coil_reset) |-> rst_len == PULSE_CYC);

  a_r2_reset_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coil_reset) |-> $past(!busy));

  a_r3_gap_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|coil_set) |-> gap_len == GAP_CYC);

  a_r3_set_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|coil_set) |-> set_len == PULSE_CYC);

  a_r6_one_coil: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({coil_set, coil_reset}) <= 1);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (coil_set == '0 && !coil_reset));

  a_r9_err_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> coil_set == '0);

  a_r10_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind relay_band_sel rbs_checker #(
  .PULSE_CYC (PULSE_CYC),
  .GAP_CYC   (GAP_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .coil_set   (coil_set),
  .coil_reset (coil_reset),
  .busy       (busy),
  .sel_err    (sel_err)
);

// File: tb/relay_band_sel_tb.sv
module relay_band_sel_tb;

  localparam int P = 6;
  localparam int G = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_sel = 8'h00;
  logic       req_ready;
  logic [5:0] coil_set;
  logic       coil_reset;
  logic       busy;
  logic       sel_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  relay_band_sel #(.PULSE_CYC(P), .GAP_CYC(G)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_sel    (req_sel),
    .coil_set   (coil_set),
    .coil_reset (coil_reset),
    .busy       (busy),
    .sel_err    (sel_err)
  );

  // R4 mapping, written from the requirement
  function automatic logic [5:0] exp_set(input logic [7:0] s);
    logic [5:0] h;
    h = {s[5], s[3], s[1], s[2], s[4], s[6]};
    return ($countones(h) == 1) ? h : 6'b0;
  endfunction

  function automatic logic exp_err(input logic [7:0] s);
    return exp_set(s) == 6'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a negedge; returns at the negedge after the accepting edge.
  task automatic send(input logic [7:0] s);
    req_valid = 1'b1;
    req_sel   = s;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(s);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || !req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: parses each sequence at the ports.
  int ph = 0, rlen = 0, glen = 0, slen = 0;
  logic [5:0] setv;

  task automatic close_seq(input logic [5:0] got);
    logic [7:0] s;
    if (exp_q.size() == 0) begin
      check(1'b0, "R7 unexpected sequence", int'(got), 0);
    end else begin
      s = exp_q.pop_front();
      check(got == exp_set(s), "R4/R5/R9 band pulsed", int'(got), int'(exp_set(s)));
      check(sel_err == exp_err(s), "R9 sel_err", int'(sel_err), int'(exp_err(s)));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({coil_set, coil_reset}) > 1)
        check(1'b0, "R6 coils", int'({coil_set, coil_reset}), 0);
      if (!busy && (coil_reset || coil_set != 0))
        check(1'b0, "R7 coil while idle", int'({coil_set, coil_reset}), 0);
      case (ph)
        0: if (coil_reset) begin
             ph = 1; rlen = 1;
             if (!busy) check(1'b0, "R7 busy with reset", 0, 1);
           end
        1: if (coil_reset) rlen++;
           else begin
             check(rlen == P, "R2 reset width", rlen, P);
             if (!busy) begin ph = 0; close_seq(6'b0); end
             else if (coil_set != 0) begin check(1'b0, "R3 no gap", 0, G); ph = 0; end
             else begin ph = 2; glen = 1; end
           end
        2: if (coil_set == 0 && busy) glen++;
           else begin
             check(glen == G, "R3 gap width", glen, G);
             ph = 3; setv = coil_set; slen = 1;
           end
        default: if (coil_set == setv && coil_set != 0) slen++;
           else begin
             check(slen == P, "R3 set width", slen, P);
             check(!busy, "R7 busy ends with set", int'(busy), 0);
             ph = 0;
             close_seq(setv);
           end
      endcase
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idle_cnt;
    logic [7:0] s;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(coil_set == 0 && !coil_reset, "R1 coils", int'({coil_set, coil_reset}), 0);
    check(!busy && !sel_err, "R1 busy/err", int'({busy, sel_err}), 0);
    check(req_ready, "R1 ready", int'(req_ready), 1);

    // R2 latency and R10 ready drop
    req_valid = 1'b1; req_sel = 8'h40;
    @(posedge clk);
    exp_q.push_back(8'h40);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10 ready low after accept", int'(req_ready), 0);
    check(!coil_reset && !busy, "R2 not yet started", int'({coil_reset, busy}), 0);
    @(negedge clk);
    check(coil_reset && busy, "R2 reset starts", int'({coil_reset, busy}), 3);
    wait_idle();

    // R4 each band
    for (int b = 1; b <= 6; b++) begin
      send(8'(1 << b));
      wait_idle();
    end
    // R5 bits 0 and 7
    send(8'h81 | 8'h10);
    wait_idle();
    send(8'h83);
    wait_idle();
    // R9 invalid selections, then recovery
    send(8'h00); wait_idle();
    check(sel_err, "R9 err after zero", int'(sel_err), 1);
    send(8'h50); wait_idle();
    send(8'h7E); wait_idle();
    send(8'h81); wait_idle();
    check(sel_err, "R9 err bits 0/7 only", int'(sel_err), 1);
    send(8'h20); wait_idle();
    check(!sel_err, "R9 err cleared", int'(sel_err), 0);

    // R8 held request
    send(8'h04);
    send(8'h08);
    check(!req_ready && busy, "R10 ready low while held", int'({req_ready, busy}), 2);
    while (busy) @(negedge clk);
    idle_cnt = 0;
    while (!busy) begin idle_cnt++; @(negedge clk); end
    check(idle_cnt == 1, "R8 idle cycles between", idle_cnt, 1);
    check(coil_reset, "R8 held starts with reset", int'(coil_reset), 1);
    wait_idle();

    // Random traffic
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 1) == 0)
        s = 8'(1 << $urandom_range(1, 6)) | (8'($urandom_range(0, 3)) & 8'h01)
            | (($urandom_range(0, 1) == 1) ? 8'h80 : 8'h00);
      else
        s = 8'($urandom);
      send(s);
      if ($urandom_range(0, 3) == 0) wait_idle();
    end
    wait_idle();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R8 all requests served", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule